// File: doc/BRIEF.md
# Sine-Pattern PWM Generator

This block drives a single-slope PWM pin whose duty cycle walks through one full cycle of a sine wave, one sample per PWM period. A free-running up-counter sets the PWM period. At each wrap of that counter a small state machine retires the compare value in use, installs the next sample from an internal read-only sine table, and advances a table pointer that wraps to the first entry after the last. Once the pin passes through an external low-pass filter, the result is a low-frequency sine whose frequency is the PWM rate divided by the table depth. With the default parameters (1920-tick period, 256 samples) a 48 MHz clock gives a 25 kHz carrier and a tone near 97.7 Hz.

The sine table is computed at elaboration from the sample width and depth parameters. The next sample is fetched ahead, during the current period, into a shadow register. It becomes the active compare value only at the period boundary. The sequencer has four named states. SEQ_IDLE holds the block at rest while it is disabled or in reset. SEQ_SETTLE is the one cycle after a wrap in which the table read address settles. SEQ_LATCH captures the prefetched sample into the shadow. SEQ_ARMED waits for the wrap. The transitions are: start (SEQ_IDLE to SEQ_LATCH when running begins), capture (SEQ_LATCH to SEQ_ARMED), commit (SEQ_ARMED to SEQ_SETTLE on a wrap), refetch (SEQ_SETTLE to SEQ_LATCH) and stop (any state to SEQ_IDLE when the block is not running). The block is running when enable is high and reset is low. `PERIOD_LAST` must be at least 2.

Top module: `sine_pwm_gen`

## Requirements
- R1: While running, the period counter steps by one each clock from 0 up to `PERIOD_LAST` and then returns to 0, so one PWM period lasts `PERIOD_LAST`+1 clocks (1920 by default).
- R2: `ovf_o` is high for exactly one clock per period: the clock in which the counter sits at `PERIOD_LAST` while the block is running. It is low otherwise.
- R3: Table entry i holds floor(H + H*sin(2*pi*i/`DEPTH`) + 0.5), with H = (2^`SAMPLE_W` - 1)/2. For a 10-bit sample, entry 0 is 512, entry `DEPTH`/4 is 1023 and entry 3*`DEPTH`/4 is 0.
- R4: While running, `pwm_o` is high exactly in the clocks where the counter value is strictly below the active compare value. The number of high clocks in a period therefore equals the sample in use, capped at the period length.
- R5: `index_o` gives the table entry used by the current period. It increases by exactly one in the clock after each `ovf_o` pulse and does not change at any other time while running.
- R6: After the period that uses entry `DEPTH`-1, the next period uses entry 0 again, so the pattern repeats every `DEPTH` periods.
- R7: The active compare value changes only at a period boundary. Within each period `pwm_o` forms a single high pulse that begins in the period's first clock, with no extra edges.
- R8: While `en_i` is low, `pwm_o` is low and the counter and `index_o` are held at 0. The first clock with `en_i` high starts a period at count 0 that uses entry 0.
- R9: While `rst_i` is high (synchronous), `pwm_o` and `ovf_o` are low and the counter and `index_o` return to 0, the same starting point as R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds the block at rest |
| pwm_o | output | 1 | PWM output pin |
| ovf_o | output | 1 | One-clock strobe on the last count of each period |
| index_o | output | $clog2(DEPTH) | Table entry in use for the current period |

## Verification
The assertions assume that `rst_i` is driven to a known value from the first clock, and that `en_i` and `rst_i` change only away from the active edge. They also assume `PERIOD_LAST` is at least 2, so the sequencer always reaches SEQ_ARMED before a wrap. The stimulus drives both inputs one time unit after a rising edge, holds reset during the opening clocks, and uses a shortened period and a 64-entry table. This keeps full table wraps, a mid-period disable and a reset applied while enabled within the run length, and the bench's reference model follows all of them clock by clock.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Sequencer states: rest, address settle, shadow capture, wait for wrap
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_LATCH  = 2'd2,
        SEQ_ARMED  = 2'd3
    } seq_state_e;

    // Wider of two widths, used to size the duty comparator
    function automatic int unsigned wider_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spwm_period_counter.sv
module spwm_period_counter #(
    parameter  int unsigned PERIOD_LAST = 1919,
    localparam int unsigned CNT_W       = $clog2(PERIOD_LAST + 1)
) (
    input  logic             clk_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PERIOD_LAST);

    logic at_last;

    assign at_last = (count_o == LAST_VAL);

    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            count_o <= '0;
        end else if (at_last) begin
            count_o <= '0;
        end else begin
            count_o <= count_o + 1'b1;
        end
    end

    // Strobe in the final count of a running period
    assign wrap_o = run_i & at_last;

endmodule

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
    parameter  int unsigned DEPTH    = 256,
    parameter  int unsigned SAMPLE_W = 10,
    parameter  int unsigned CMP_W    = 16,
    localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic [IDX_W-1:0] addr_i,
    output logic [CMP_W-1:0] data_o
);

    localparam real TWO_PI = 6.283185307179586;
    localparam real MID    = ((2.0 ** SAMPLE_W) - 1.0) / 2.0;

    logic [CMP_W-1:0] wave_w [DEPTH];

    // One sine cycle, centred on mid-scale, rounded to nearest
    for (genvar g = 0; g < DEPTH; g++) begin : g_wave
        localparam real ANGLE  = TWO_PI * g / DEPTH;
        localparam int  SAMPLE = int'($floor(MID + MID * $sin(ANGLE) + 0.5));
        assign wave_w[g] = CMP_W'(SAMPLE);
    end

    always_ff @(posedge clk_i) begin
        data_o <= wave_w[addr_i];
    end

endmodule

// File: rtl/spwm_sequencer.sv
module spwm_sequencer
    import spwm_pkg::*;
#(
    parameter  int unsigned DEPTH    = 256,
    parameter  int unsigned SAMPLE_W = 10,
    parameter  int unsigned CMP_W    = 16,
    localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             run_i,
    input  logic             wrap_i,
    input  logic [CMP_W-1:0] sample_i,
    output logic [IDX_W-1:0] rd_addr_o,
    output logic [IDX_W-1:0] index_o,
    output logic [CMP_W-1:0] compare_o,
    output seq_state_e       state_o
);

    // Entry 0 of a mid-centred sine is always half scale
    localparam logic [CMP_W-1:0] FIRST_SAMPLE = CMP_W'(2 ** (SAMPLE_W - 1));
    localparam logic [IDX_W-1:0] LAST_IDX     = IDX_W'(DEPTH - 1);

    seq_state_e       state_q;
    seq_state_e       state_nx;
    logic [IDX_W-1:0] idx_nx;
    logic [CMP_W-1:0] shadow_q;

    assign idx_nx    = (index_o == LAST_IDX) ? '0 : index_o + 1'b1;
    assign rd_addr_o = idx_nx;
    assign state_o   = state_q;

    // State register
    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: start, capture, commit, refetch
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_IDLE:   state_nx = SEQ_LATCH;
            SEQ_SETTLE: state_nx = SEQ_LATCH;
            SEQ_LATCH:  state_nx = SEQ_ARMED;
            SEQ_ARMED:  state_nx = wrap_i ? SEQ_SETTLE : SEQ_ARMED;
            default:    state_nx = SEQ_IDLE;
        endcase
    end

    // Registered outputs: shadow capture and boundary commit
    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            index_o   <= '0;
            compare_o <= FIRST_SAMPLE;
            shadow_q  <= FIRST_SAMPLE;
        end else begin
            unique case (state_q)
                SEQ_LATCH: begin
                    shadow_q <= sample_i;
                end
                SEQ_ARMED: begin
                    if (wrap_i) begin
                        compare_o <= shadow_q;
                        index_o   <= idx_nx;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen
    import spwm_pkg::*;
#(
    parameter  int unsigned PERIOD_LAST = 1919,
    parameter  int unsigned DEPTH       = 256,
    parameter  int unsigned SAMPLE_W    = 10,
    parameter  int unsigned CMP_W       = 16,
    localparam int unsigned IDX_W       = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic             pwm_o,
    output logic             ovf_o,
    output logic [IDX_W-1:0] index_o
);

    localparam int unsigned CNT_W  = $clog2(PERIOD_LAST + 1);
    localparam int unsigned CMPX_W = wider_of(CNT_W, CMP_W);

    logic             run;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] rd_addr;
    logic [CMP_W-1:0] rom_q;
    logic [CMP_W-1:0] cmp_act;
    seq_state_e       seq_state;

    assign run = en_i & ~rst_i;

    spwm_period_counter #(
        .PERIOD_LAST (PERIOD_LAST)
    ) u_counter (
        .clk_i   (clk_i),
        .run_i   (run),
        .count_o (cnt_q),
        .wrap_o  (ovf_o)
    );

    spwm_sine_rom #(
        .DEPTH    (DEPTH),
        .SAMPLE_W (SAMPLE_W),
        .CMP_W    (CMP_W)
    ) u_rom (
        .clk_i  (clk_i),
        .addr_i (rd_addr),
        .data_o (rom_q)
    );

    spwm_sequencer #(
        .DEPTH    (DEPTH),
        .SAMPLE_W (SAMPLE_W),
        .CMP_W    (CMP_W)
    ) u_seq (
        .clk_i     (clk_i),
        .run_i     (run),
        .wrap_i    (ovf_o),
        .sample_i  (rom_q),
        .rd_addr_o (rd_addr),
        .index_o   (index_o),
        .compare_o (cmp_act),
        .state_o   (seq_state)
    );

    // Single-slope compare: high while count is below the active sample
    assign pwm_o = run & (CMPX_W'(cnt_q) < CMPX_W'(cmp_act));

endmodule

// File: rtl/spwm_checker.sv
module spwm_checker
    import spwm_pkg::*;
#(
    parameter  int unsigned PERIOD_LAST = 1919,
    parameter  int unsigned DEPTH       = 256,
    parameter  int unsigned CMP_W       = 16,
    localparam int unsigned CNT_W       = $clog2(PERIOD_LAST + 1),
    localparam int unsigned IDX_W       = $clog2(DEPTH)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic             pwm_i,
    input logic             ovf_i,
    input logic [IDX_W-1:0] index_i,
    input logic [CNT_W-1:0] count_i,
    input logic [CMP_W-1:0] compare_i,
    input seq_state_e       state_i
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_LAST);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && count_i != LAST_CNT |=> count_i == $past(count_i) + 1'b1);

    assert_count_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_i |=> count_i == '0);

    assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        count_i <= LAST_CNT);

    assert_ovf_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_i |=> !ovf_i);

    assert_index_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_i && index_i != LAST_IDX |=> index_i == $past(index_i) + 1'b1);

    assert_index_wrap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_i && index_i == LAST_IDX |=> index_i == '0);

    assert_cmp_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && !ovf_i |=> $stable(compare_i) && $stable(index_i));

    assert_wrap_armed_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_i |-> state_i == SEQ_ARMED);

    assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !pwm_i && !ovf_i);

    assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> count_i == '0 && index_i == '0);

    assert_reset_zero_R9: assert property (@(posedge clk_i)
        rst_i |=> count_i == '0 && index_i == '0 && state_i == SEQ_IDLE);

endmodule

bind sine_pwm_gen spwm_checker #(
    .PERIOD_LAST (PERIOD_LAST),
    .DEPTH       (DEPTH),
    .CMP_W       (CMP_W)
) u_spwm_checker (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .pwm_i     (pwm_o),
    .ovf_i     (ovf_o),
    .index_i   (index_o),
    .count_i   (cnt_q),
    .compare_i (cmp_act),
    .state_i   (seq_state)
);

// File: tb/test_sine_pwm_gen.sv
`timescale 1ns/1ps
module test_sine_pwm_gen;

    localparam int PER  = 1099;
    localparam int DEP  = 64;
    localparam int SW   = 10;
    localparam int CW   = 16;
    localparam int IW   = $clog2(DEP);
    localparam int PLEN = PER + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          pwm;
    logic          ovf;
    logic [IW-1:0] index;

    sine_pwm_gen #(
        .PERIOD_LAST (PER),
        .DEPTH       (DEP),
        .SAMPLE_W    (SW),
        .CMP_W       (CW)
    ) i_sine_pwm_gen (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .pwm_o   (pwm),
        .ovf_o   (ovf),
        .index_o (index)
    );

    always #2 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  refv [DEP];
    int  mcnt = 0;
    int  midx = 0;
    bit  started = 0;
    bit  done = 0;
    int  cyc = 0;

    // period statistics
    int  len = 0;
    int  hi = 0;
    int  rises = 0;
    bit  first_hi = 0;
    bit  prev_pwm = 0;
    bit  pend = 0;
    int  last_idx = 0;
    bit  fresh = 0;
    int  wraps = 0;
    bit  act_now;
    bit  exp_pwm;
    bit  exp_ovf;
    int  exp_duty;
    string tag;

    task automatic chk(input bit ok, input string what, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, actual, expected);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reference sine from the R3 formula
    initial begin
        for (int i = 0; i < DEP; i++) begin
            refv[i] = int'($floor(511.5 + 511.5 * $sin(2.0 * 3.141592653589793 * real'(i) / real'(DEP)) + 0.5));
        end
    end

    // Behavioural model of count and entry, advanced at each edge
    always @(posedge clk) begin
        if (rst) started = 1;
        if (!(en && !rst)) begin
            mcnt = 0;
            midx = 0;
        end else if (mcnt == PER) begin
            mcnt = 0;
            midx = (midx + 1) % DEP;
        end else begin
            mcnt = mcnt + 1;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            act_now = en && !rst;
            tag = rst ? "R9" : (!en ? "R8" : "R4");
            exp_pwm = act_now && (mcnt < refv[midx]);
            exp_ovf = act_now && (mcnt == PER);
            chk(pwm === exp_pwm, {tag, " pwm level"}, int'(pwm), int'(exp_pwm));
            chk(ovf === exp_ovf, {tag == "R4" ? "R2" : tag, " overflow strobe"}, int'(ovf), int'(exp_ovf));
            chk(int'(index) == midx, {tag == "R4" ? "R5" : tag, " table index"}, int'(index), midx);

            if (!act_now) begin
                len = 0; hi = 0; rises = 0; pend = 0; fresh = 1;
            end else begin
                len++;
                if (len == 1) first_hi = pwm;
                if (pwm) hi++;
                if (pwm && (len == 1 || !prev_pwm)) rises++;
                if (pend) begin
                    if (last_idx == DEP - 1) begin
                        chk(int'(index) == 0, "R6 index wraps to entry 0", int'(index), 0);
                        wraps++;
                    end else begin
                        chk(int'(index) == last_idx + 1, "R5 index steps by one", int'(index), last_idx + 1);
                    end
                    pend = 0;
                end
                if (ovf) begin
                    exp_duty = (refv[midx] > PLEN) ? PLEN : refv[midx];
                    chk(len == PLEN, "R1 period length", len, PLEN);
                    chk(hi == exp_duty, "R4 duty of period", hi, exp_duty);
                    chk(rises <= 1 && (exp_duty == 0 || first_hi), "R7 single pulse from period start", rises, 1);
                    if (midx == DEP / 4)     chk(hi == 1023, "R3 peak sample", hi, 1023);
                    if (midx == 3 * DEP / 4) chk(hi == 0, "R3 trough sample", hi, 0);
                    if (fresh) begin
                        chk(int'(index) == 0 && hi == 512, "R8 first period uses entry 0", hi, 512);
                        fresh = 0;
                    end
                    last_idx = int'(index);
                    pend = 1;
                    len = 0; hi = 0; rises = 0;
                end
            end
            prev_pwm = pwm;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            errors++;
            $display("FAIL R1 watchdog actual %0d expected below %0d", cyc, 200000);
            finish_up();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(3);
        // main run across more than one full table cycle
        en = 1'b1;
        step((DEP + 2) * PLEN);
        // disable part-way through a period, then restart
        step(300);
        en = 1'b0;
        step(40);
        en = 1'b1;
        step(2 * PLEN + 10);
        // reset while enabled
        rst = 1'b1;
        step(5);
        rst = 1'b0;
        step(PLEN + 20);
        chk(wraps >= 1, "R6 table wrap observed", wraps, 1);
        en = 1'b0;
        step(3);
        finish_up();
    end

endmodule